// File: doc/BRIEF.md
# Audio Stream Double-Buffered Address Controller

This block keeps the memory addresses for one capture stream (audio coming in) and one playback stream (audio going out). Each stream has a current address, which the memory mover uses, and a next address, which software preloads while the current buffer is in use. Each accepted sample moves the current address forward by 2 bytes for 16-bit stored samples or by 3 bytes for 24-bit stored samples. After a programmed number of samples the buffer is finished. The next address then moves into the current slot, and the next slot reads as zero again.

If a buffer finishes while the next slot is still zero, the refresh was missed. The block treats this as fatal: it raises a pointer error and clears the length register, which halts both streams. To stop in an orderly way, software stops supplying next addresses and waits for this error. At that point the stream's current and next addresses both read zero, which shows that it has drained. A set of sticky flags, a mask and a write-one-to-clear register produce a single interrupt line.

Top module: `audptr_ctrl`

## Requirements
- R1: After reset, every address, the length register, the flags, the masked flags and `irq` are zero, and `running` is low.
- R2: Register writes use the following offsets: 0 = sample length, 1 = capture next address, 2 = playback next address, 3 = mask, 4 = write-one-to-clear. Writing a nonzero length while the length is zero copies each next address into its current address in that same cycle, and the next addresses then read zero.
- R3: While running, each strobe on a stream whose current address is nonzero advances that address by 2 when `wide_smp` is 0 and by 3 when it is 1. Strobes have no effect on a stream whose current address is zero.
- R4: On the strobe that completes `dma_len` samples, the next address becomes the current address, the next address reads zero, and a done flag is set: bit 5 for capture, bit 4 for playback.
- R5: If a buffer completes while its next address is zero, the current address becomes zero, flag bit 0 is set, and the length is cleared. After that, strobes on either stream have no effect.
- R6: Writing a length of zero stops the block at once, and later strobes leave the addresses unchanged.
- R7: A pulse on `line_evt[0]`, `line_evt[1]` or `line_evt[2]` sets flag bit 1, bit 2 or bit 3 respectively. Flags stay set until they are cleared.
- R8: Writing a 1 to a bit at offset 4 clears that flag. If the same flag is set by an event in the same cycle, the event wins.
- R9: `masked_flags` equals the flags ANDed with the mask, and `irq` is high exactly when any masked flag is set.
- R10: If a next address is written in the same cycle that the old next address is consumed, the old value moves into the current address and the newly written value is kept as the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| in_smp_stb | input | 1 | One capture sample moved |
| out_smp_stb | input | 1 | One playback sample moved |
| wide_smp | input | 1 | 1 = 3-byte stored samples, 0 = 2-byte |
| line_evt | input | 3 | Word clock error, bus error, word clock timeout events |
| in_cur | output | ADDR_W | Capture current address |
| in_nxt | output | ADDR_W | Capture next address |
| out_cur | output | ADDR_W | Playback current address |
| out_nxt | output | ADDR_W | Playback next address |
| dma_len | output | LEN_W | Samples per buffer; zero = stopped |
| running | output | 1 | Length is nonzero |
| raw_flags | output | 6 | Sticky flags |
| masked_flags | output | 6 | Flags ANDed with the mask |
| irq | output | 1 | OR of the masked flags |

## Verification
Several properties are checked on every cycle: the interrupt line always agrees with the flags and the mask, write-one-to-clear and flag stickiness hold bit by bit, a missed refresh zeroes the current address and clears the length on the next edge, a consumed next address reads zero, and a stopped stream never moves its address. Other behaviour can only be shown by the bench's scenarios. This includes the exact addresses after a run of strobes with each sample width, the buffer boundary landing on the programmed count, an orderly drain to zero addresses, and the write arriving in the same cycle as the swap.

// File: rtl/audptr_pkg.sv
package audptr_pkg;
  localparam int NFLAG = 6;
  // flag bit positions
  localparam int F_PTR  = 0;
  localparam int F_WCE  = 1;
  localparam int F_BUS  = 2;
  localparam int F_TMO  = 3;
  localparam int F_ODN  = 4;
  localparam int F_IDN  = 5;
  // register offsets
  localparam logic [2:0] RA_LEN   = 3'd0;
  localparam logic [2:0] RA_INNXT = 3'd1;
  localparam logic [2:0] RA_OUTNXT= 3'd2;
  localparam logic [2:0] RA_MASK  = 3'd3;
  localparam logic [2:0] RA_CLR   = 3'd4;
endpackage

// File: rtl/audptr_stream.sv
module audptr_stream #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              start,
  input  logic              stb,
  input  logic              wide,
  input  logic [LEN_W-1:0]  len,
  input  logic              nxt_we,
  input  logic [ADDR_W-1:0] nxt_wdata,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              end_o,
  output logic              miss_o
);
  logic [ADDR_W-1:0] cur_q, nxt_q;
  logic [LEN_W-1:0]  cnt_q;
  logic take, last, consume;
  logic [ADDR_W-1:0] step;

  assign take    = active && stb && (cur_q != '0);
  assign last    = take && (cnt_q >= (len - LEN_W'(1)));
  assign consume = start || last;
  assign step    = wide ? ADDR_W'(3) : ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      nxt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (start) begin
        cur_q <= nxt_q;
        cnt_q <= '0;
      end else if (!active) begin
        cnt_q <= '0;
      end else if (last) begin
        cur_q <= nxt_q;
        cnt_q <= '0;
      end else if (take) begin
        cur_q <= cur_q + step;
        cnt_q <= cnt_q + LEN_W'(1);
      end
      if (nxt_we)       nxt_q <= nxt_wdata;
      else if (consume) nxt_q <= '0;
    end
  end

  assign cur_o  = cur_q;
  assign nxt_o  = nxt_q;
  assign end_o  = last;
  assign miss_o = last && (nxt_q == '0);

  a_r5_miss_zeroes: assert property (@(posedge clk) disable iff (rst)
    miss_o |=> cur_q == '0);
  a_r4_next_consumed: assert property (@(posedge clk) disable iff (rst)
    (consume && !nxt_we) |=> nxt_q == '0);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> $stable(cur_q));
  a_r3_step_size: assert property (@(posedge clk) disable iff (rst)
    (take && !last) |=> ((cur_q - $past(cur_q)) == ADDR_W'(2) || (cur_q - $past(cur_q)) == ADDR_W'(3)));
endmodule

// File: rtl/audptr_irq.sv
module audptr_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q, raw_d, mask_d, clr_v;
  logic irq_q;

  assign clr_v  = clr_we ? clr_wdata : '0;
  assign raw_d  = (raw_q & ~clr_v) | set;
  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(raw_q & mask_q));

  for (genvar k = 0; k < N; k++) begin : g_bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_wdata[k] && !set[k]) |=> !raw_q[k]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (raw_q[k] && !(clr_we && clr_wdata[k])) |=> raw_q[k]);
  end
endmodule

// File: rtl/audptr_ctrl.sv
module audptr_ctrl
  import audptr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              in_smp_stb,
  input  logic              out_smp_stb,
  input  logic              wide_smp,
  input  logic [2:0]        line_evt,
  output logic [ADDR_W-1:0] in_cur,
  output logic [ADDR_W-1:0] in_nxt,
  output logic [ADDR_W-1:0] out_cur,
  output logic [ADDR_W-1:0] out_nxt,
  output logic [LEN_W-1:0]  dma_len,
  output logic              running,
  output logic [NFLAG-1:0]  raw_flags,
  output logic [NFLAG-1:0]  masked_flags,
  output logic              irq
);
  logic [LEN_W-1:0] len_q;
  logic len_we, start, active, miss_any;
  logic in_end, in_miss, out_end, out_miss;
  logic [NFLAG-1:0] set, mask_q;

  assign len_we   = reg_we && (reg_addr == RA_LEN);
  assign active   = (len_q != '0);
  assign start    = len_we && (reg_wdata[LEN_W-1:0] != '0) && !active;
  assign miss_any = in_miss || out_miss;

  always_ff @(posedge clk) begin
    if (rst)           len_q <= '0;
    else if (miss_any) len_q <= '0;
    else if (len_we)   len_q <= reg_wdata[LEN_W-1:0];
  end

  audptr_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_in (
    .clk(clk), .rst(rst), .active(active), .start(start), .stb(in_smp_stb),
    .wide(wide_smp), .len(len_q),
    .nxt_we(reg_we && (reg_addr == RA_INNXT)), .nxt_wdata(reg_wdata),
    .cur_o(in_cur), .nxt_o(in_nxt), .end_o(in_end), .miss_o(in_miss));

  audptr_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst(rst), .active(active), .start(start), .stb(out_smp_stb),
    .wide(wide_smp), .len(len_q),
    .nxt_we(reg_we && (reg_addr == RA_OUTNXT)), .nxt_wdata(reg_wdata),
    .cur_o(out_cur), .nxt_o(out_nxt), .end_o(out_end), .miss_o(out_miss));

  always_comb begin
    set        = '0;
    set[F_PTR] = miss_any;
    set[F_WCE] = line_evt[0];
    set[F_BUS] = line_evt[1];
    set[F_TMO] = line_evt[2];
    set[F_ODN] = out_end;
    set[F_IDN] = in_end;
  end

  audptr_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .set(set),
    .mask_we(reg_we && (reg_addr == RA_MASK)), .mask_wdata(reg_wdata[NFLAG-1:0]),
    .clr_we(reg_we && (reg_addr == RA_CLR)), .clr_wdata(reg_wdata[NFLAG-1:0]),
    .raw_o(raw_flags), .mask_o(mask_q), .irq_o(irq));

  assign masked_flags = raw_flags & mask_q;
  assign dma_len      = len_q;
  assign running      = active;

  a_r5_stop_on_miss: assert property (@(posedge clk) disable iff (rst)
    miss_any |=> (len_q == '0));
  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (len_q != '0));
endmodule

// File: tb/sim_audptr_ctrl.sv
module sim_audptr_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic in_smp_stb = 1'b0, out_smp_stb = 1'b0, wide_smp = 1'b0;
  logic [2:0] line_evt = '0;
  logic [31:0] in_cur, in_nxt, out_cur, out_nxt;
  logic [7:0] dma_len;
  logic running, irq;
  logic [5:0] raw_flags, masked_flags;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audptr_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic stb_in(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_smp_stb = 1;
      @(negedge clk); in_smp_stb = 0;
    end
  endtask

  task automatic t_reset();
    chk(in_cur == 0 && in_nxt == 0 && out_cur == 0 && out_nxt == 0, "R1", in_cur | out_cur, 0);
    chk(dma_len == 0 && !running, "R1", dma_len, 0);
    chk(raw_flags == 0 && masked_flags == 0 && !irq, "R1", raw_flags, 0);
  endtask

  task automatic t_start_and_swap();
    wr(3'd1, 32'h1000); wr(3'd2, 32'h2000); wr(3'd0, 4);
    chk(in_cur == 32'h1000, "R2", in_cur, 32'h1000);
    chk(in_nxt == 0 && out_nxt == 0, "R2", in_nxt | out_nxt, 0);
    chk(out_cur == 32'h2000 && running, "R2", out_cur, 32'h2000);
    stb_in(1);
    chk(in_cur == 32'h1002, "R3", in_cur, 32'h1002);
    wr(3'd1, 32'h1100);
    stb_in(3);
    chk(in_cur == 32'h1100, "R4", in_cur, 32'h1100);
    chk(in_nxt == 0, "R4", in_nxt, 0);
    chk(raw_flags == 6'h20, "R4", raw_flags, 6'h20);
    chk(out_cur == 32'h2000, "R3", out_cur, 32'h2000);
  endtask

  task automatic t_drain();
    stb_in(4);
    chk(in_cur == 0 && in_nxt == 0, "R5", in_cur, 0);
    chk(raw_flags == 6'h21, "R5", raw_flags, 6'h21);
    chk(dma_len == 0 && !running, "R5", dma_len, 0);
    @(negedge clk); out_smp_stb = 1; @(negedge clk); out_smp_stb = 0;
    chk(out_cur == 32'h2000, "R5", out_cur, 32'h2000);
    wr(3'd4, 32'h3F);
    chk(raw_flags == 0, "R8", raw_flags, 0);
  endtask

  task automatic t_wide_stop();
    wide_smp = 1;
    wr(3'd1, 32'h3000); wr(3'd0, 2);
    chk(in_cur == 32'h3000 && out_cur == 0, "R2", in_cur, 32'h3000);
    stb_in(1);
    chk(in_cur == 32'h3003, "R3", in_cur, 32'h3003);
    wr(3'd0, 0);
    chk(!running, "R6", running, 0);
    stb_in(2);
    chk(in_cur == 32'h3003, "R6", in_cur, 32'h3003);
    chk(raw_flags == 0, "R6", raw_flags, 0);
  endtask

  task automatic t_flags();
    @(negedge clk); line_evt = 3'b101; @(negedge clk); line_evt = 0;
    chk(raw_flags == 6'h0A, "R7", raw_flags, 6'h0A);
    chk(!irq, "R9", irq, 0);
    wr(3'd3, 32'h08);
    chk(masked_flags == 6'h08 && irq, "R9", masked_flags, 6'h08);
    wr(3'd3, 32'h04);
    chk(masked_flags == 0 && !irq, "R9", masked_flags, 0);
    @(negedge clk); line_evt = 3'b001; reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h0A;
    @(negedge clk); line_evt = 0; reg_we = 0;
    chk(raw_flags == 6'h02, "R8", raw_flags, 6'h02);
    wr(3'd4, 32'h3F);
    chk(raw_flags == 0, "R8", raw_flags, 0);
  endtask

  task automatic t_race();
    wide_smp = 0;
    wr(3'd1, 32'h4000); wr(3'd0, 1);
    chk(in_cur == 32'h4000, "R2", in_cur, 32'h4000);
    wr(3'd1, 32'h5000);
    @(negedge clk); in_smp_stb = 1; reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h6000;
    @(negedge clk); in_smp_stb = 0; reg_we = 0;
    chk(in_cur == 32'h5000, "R10", in_cur, 32'h5000);
    chk(in_nxt == 32'h6000, "R10", in_nxt, 32'h6000);
    chk(raw_flags == 6'h20 && running, "R10", raw_flags, 6'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_start_and_swap();
    t_drain();
    t_wide_stop();
    t_flags();
    t_race();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule